// File: doc/BRIEF.md
# Banked Interrupt Request Aggregator

This block collects twenty-four interrupt request lines into a single interrupt output for a host processor. Each input is brought into the clock domain through a two-stage synchroniser. Rising edges on most inputs are latched into status bits. One input, chosen by a parameter, is level-type, and its status bit simply mirrors the synchronised input level. The status and enable bits are arranged as three byte-wide banks on a small register bus.

Software enables sources by writing 1s into a bank's enable byte. It services the line by reading status bytes. A status read returns the byte one cycle after the strobe, and clears the latched edge bits it returned in the same cycle. The output is high while any enabled status bit is set. The host detects this output on its rising edge. For that reason, a new enabled event that arrives while the output is already high forces the output low for exactly one cycle, so that a fresh rising edge reaches the host.

Top module: `irq_byte_aggregator`

## Requirements
- R1: After reset the output is low, every status byte reads 0x00 and every enable byte reads 0x00.
- R2: A rising edge on source n sets bit n%8 of the status byte for bank n/8 (status offsets 0, 2, 4 for sources 0-7, 8-15, 16-23). The bit is set whether or not the source is enabled.
- R3: Reading a status byte clears the edge-type bits it returned. Status bits in the other banks are left unchanged.
- R4: If a new rising edge on a source is detected in the same cycle as the read that clears its bank, the bit stays set and the next read returns it.
- R5: Source 12 (bank at offset 2, bit 4) is level-type. Its status bit equals the synchronised input level, and a status read never clears it.
- R6: Enable bytes at offsets 1, 3 and 5 (sources 0-7, 8-15, 16-23) can be written and read back. A 1 enables the matching source.
- R7: The output is the registered OR of status AND enable. It stays low for pending sources that are disabled. It rises once such a source is enabled, and it falls after the pending bits have been cleared.
- R8: A new enabled rising edge that is detected while the output is high drives the output low for exactly one cycle, after which it returns high.
- R9: Read data is registered and valid in the cycle after the read strobe. It holds its value when there is no read. Offsets 6 and 7 read 0x00.
- R10: Only a low-to-high transition latches a status bit. An input held high does not set its bit again after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 24 | Asynchronous interrupt request inputs |
| busAddr | input | 3 | Register offset |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| irqOut | output | 1 | Aggregated interrupt output |

## Verification
Single pulses are placed in each bank, including while the source is disabled. This shows whether the status bits latch independently of the enables and whether a read clears only its own bank. One input is held high across several reads, and the level-type input is raised and lowered. These patterns separate true edge detection from level following. A second enabled pulse while the output is high, and an edge timed into the same cycle as a clearing read, expose a missing one-cycle dip and lost events. Reads at unused offsets and idle cycles after a read check the decode and the holding of the read register.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int BANKS      = 3;
  localparam int BANK_W     = 8;
  localparam int SRC_N      = BANKS * BANK_W;
  localparam int ADDR_W     = 3;
  localparam int BANK_SEL_W = $clog2(BANKS);

  typedef struct packed {
    logic [BANKS-1:0]      clrBank;
    logic [BANKS-1:0]      wrBank;
    logic                  rdEn;
    logic                  rdValid;
    logic                  rdIsMask;
    logic [BANK_SEL_W-1:0] rdBank;
  } aggStrobe_t;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output aggStrobe_t        strb
);
  logic                  inRange;
  logic                  isMask;
  logic [ADDR_W-2:0]     bankIdx;

  assign isMask  = busAddr[0];
  assign bankIdx = busAddr[ADDR_W-1:1];
  assign inRange = (int'(busAddr) < 2 * BANKS);

  always_comb begin
    strb          = '0;
    strb.rdEn     = busRd;
    strb.rdValid  = inRange;
    strb.rdIsMask = isMask;
    strb.rdBank   = bankIdx[BANK_SEL_W-1:0];
    for (int b = 0; b < BANKS; b++) begin
      if (inRange && int'(bankIdx) == b) begin
        strb.clrBank[b] = busRd && !isMask;
        strb.wrBank[b]  = busWr && isMask;
      end
    end
  end
endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int LEVEL_SRC = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_N-1:0]  irqIn,
  input  aggStrobe_t        strb,
  input  logic [BANK_W-1:0] wrData,
  output logic [BANK_W-1:0] rdData,
  output logic              irqOut,
  output logic [SRC_N-1:0]  statusVec,
  output logic [SRC_N-1:0]  maskVec,
  output logic [SRC_N-1:0]  riseVec,
  output logic              newEvt
);
  localparam logic [SRC_N-1:0] LEVEL_MASK = SRC_N'(1) << LEVEL_SRC;

  logic [SRC_N-1:0] syncA, syncB, prevB;
  logic [SRC_N-1:0] edgeStat;
  logic [SRC_N-1:0] clrVec;
  logic             pending;
  logic [BANK_W-1:0] rdMux;

  // two-flop synchroniser plus history flop for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= irqIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  assign riseVec = syncB & ~prevB;

  genvar b, i;
  generate
    for (b = 0; b < BANKS; b++) begin : g_bank
      assign clrVec[b*BANK_W +: BANK_W] = {BANK_W{strb.clrBank[b]}};

      always_ff @(posedge clk) begin
        if (!rstN)
          maskVec[b*BANK_W +: BANK_W] <= '0;
        else if (strb.wrBank[b])
          maskVec[b*BANK_W +: BANK_W] <= wrData;
      end
    end

    for (i = 0; i < SRC_N; i++) begin : g_src
      if (i == LEVEL_SRC) begin : g_level
        assign statusVec[i] = syncB[i];
      end else begin : g_edge
        assign statusVec[i] = edgeStat[i];
      end
    end
  endgenerate

  // set wins over clear so an edge landing on the clearing read survives
  always_ff @(posedge clk) begin
    if (!rstN)
      edgeStat <= '0;
    else
      edgeStat <= ((edgeStat & ~clrVec) | riseVec) & ~LEVEL_MASK;
  end

  assign newEvt  = |(riseVec & maskVec);
  assign pending = |(statusVec & maskVec);

  always_ff @(posedge clk) begin
    if (!rstN)
      irqOut <= 1'b0;
    else
      irqOut <= pending && !(irqOut && newEvt);
  end

  always_comb begin
    rdMux = '0;
    for (int k = 0; k < BANKS; k++) begin
      if (int'(strb.rdBank) == k)
        rdMux = strb.rdIsMask ? maskVec[k*BANK_W +: BANK_W]
                              : statusVec[k*BANK_W +: BANK_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      rdData <= '0;
    else if (strb.rdEn)
      rdData <= strb.rdValid ? rdMux : '0;
  end
endmodule

// File: rtl/irq_byte_aggregator.sv
module irq_byte_aggregator
  import irq_agg_pkg::*;
#(
  parameter int LEVEL_SRC = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_N-1:0]  irqIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [BANK_W-1:0] busWdata,
  output logic [BANK_W-1:0] busRdata,
  output logic              irqOut
);
  aggStrobe_t       strb;
  logic [SRC_N-1:0] statusVec;
  logic [SRC_N-1:0] maskVec;
  logic [SRC_N-1:0] riseVec;
  logic             newEvt;

  irq_agg_ctrl u_ctrl (
    .busRd   (busRd),
    .busWr   (busWr),
    .busAddr (busAddr),
    .strb    (strb)
  );

  irq_agg_datapath #(.LEVEL_SRC(LEVEL_SRC)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .irqIn     (irqIn),
    .strb      (strb),
    .wrData    (busWdata),
    .rdData    (busRdata),
    .irqOut    (irqOut),
    .statusVec (statusVec),
    .maskVec   (maskVec),
    .riseVec   (riseVec),
    .newEvt    (newEvt)
  );
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker
  import irq_agg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic [BANK_W-1:0] busWdata,
  input logic [BANK_W-1:0] busRdata,
  input logic              irqOut,
  input logic [SRC_N-1:0]  statusVec,
  input logic [SRC_N-1:0]  maskVec,
  input logic [SRC_N-1:0]  riseVec,
  input logic              newEvt
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> !irqOut);

  // low bank holds only edge-type sources with the default level index
  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == 3'd0) |=>
      ((statusVec[7:0] & $past(statusVec[7:0]) & ~$past(riseVec[7:0])) == 8'h00));

  assert_mask_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 3'd1) |=> (maskVec[7:0] == $past(busWdata)));

  assert_out_needs_pending_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(|(statusVec & maskVec)));

  assert_redip_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && newEvt) |=> !irqOut);

  assert_unused_offset_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr >= 3'd6) |=> (busRdata == 8'h00));

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> $stable(busRdata));
endmodule

bind irq_byte_aggregator irq_agg_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busRd     (busRd),
  .busWr     (busWr),
  .busWdata  (busWdata),
  .busRdata  (busRdata),
  .irqOut    (irqOut),
  .statusVec (statusVec),
  .maskVec   (maskVec),
  .riseVec   (riseVec),
  .newEvt    (newEvt)
);

// File: tb/irq_byte_aggregator_bench.sv
module irq_byte_aggregator_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] irqIn = '0;
  logic [2:0]  busAddr = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic        irqOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_byte_aggregator u_irq_byte_aggregator (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busAddr(busAddr),
    .busRd(busRd), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic check(input string req, input int actual, input int expected);
    testsRun++;
    if (actual != expected) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busRead(input logic [2:0] addr, output logic [7:0] data);
    @(negedge clk);
    busAddr = addr; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    data = busRdata;
  endtask

  task automatic busWrite(input logic [2:0] addr, input logic [7:0] data);
    @(negedge clk);
    busAddr = addr; busWdata = data; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic pulse(input int src);
    irqIn[src] = 1'b1;
    idle(3);
    irqIn[src] = 1'b0;
    idle(4);
  endtask

  task automatic clearAll();
    logic [7:0] d;
    busWrite(3'd1, 8'h00); busWrite(3'd3, 8'h00); busWrite(3'd5, 8'h00);
    busRead(3'd0, d); busRead(3'd2, d); busRead(3'd4, d);
    idle(2);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 irqOut after reset", irqOut, 0);
    for (int a = 0; a < 6; a++) begin
      busRead(3'(a), d);
      check("R1 register after reset", d, 0);
    end
  endtask

  task automatic t_maskRw();
    logic [7:0] d;
    busWrite(3'd1, 8'hA5); busWrite(3'd3, 8'h3C); busWrite(3'd5, 8'h81);
    busRead(3'd1, d); check("R6 low enable readback", d, 8'hA5);
    busRead(3'd3, d); check("R6 high enable readback", d, 8'h3C);
    busRead(3'd5, d); check("R6 third enable readback", d, 8'h81);
    clearAll();
  endtask

  task automatic t_edgeMasked();
    logic [7:0] d;
    pulse(3);
    check("R7 disabled source keeps output low", irqOut, 0);
    busRead(3'd0, d); check("R2 disabled edge latched", d, 8'h08);
    busRead(3'd0, d); check("R3 bit cleared by read", d, 8'h00);
  endtask

  task automatic t_bankIsolation();
    logic [7:0] d;
    pulse(9); pulse(17);
    busRead(3'd4, d); check("R2 third bank edge", d, 8'h02);
    busRead(3'd2, d); check("R3 high bank untouched by third read", d, 8'h02);
    busRead(3'd4, d); check("R3 third bank cleared", d, 8'h00);
    busRead(3'd2, d); check("R3 high bank cleared", d, 8'h00);
  endtask

  task automatic t_output();
    logic [7:0] d;
    busWrite(3'd1, 8'h02);
    pulse(1);
    check("R7 enabled pending raises output", irqOut, 1);
    busRead(3'd0, d); check("R2 enabled edge latched", d, 8'h02);
    idle(2);
    check("R7 output falls after clear", irqOut, 0);
    pulse(2);
    check("R7 disabled pending keeps low", irqOut, 0);
    busWrite(3'd1, 8'h04);
    idle(1);
    check("R7 output rises on enable", irqOut, 1);
    clearAll();
  endtask

  task automatic t_redip();
    int lows = 0;
    busWrite(3'd1, 8'h30);
    pulse(4);
    check("R7 first event raises output", irqOut, 1);
    irqIn[5] = 1'b1;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (irqOut == 1'b0) lows++;
      if (c == 3) irqIn[5] = 1'b0;
    end
    check("R8 one-cycle dip count", lows, 1);
    check("R8 output back high", irqOut, 1);
    clearAll();
  endtask

  task automatic t_level();
    logic [7:0] d;
    busWrite(3'd3, 8'h10);
    irqIn[12] = 1'b1;
    idle(4);
    busRead(3'd2, d); check("R5 level bit set", d, 8'h10);
    busRead(3'd2, d); check("R5 level bit not cleared by read", d, 8'h10);
    check("R5 level drives output", irqOut, 1);
    irqIn[12] = 1'b0;
    idle(4);
    busRead(3'd2, d); check("R5 level bit follows low", d, 8'h00);
    check("R5 output low after level drops", irqOut, 0);
    clearAll();
  endtask

  task automatic t_collision();
    logic [7:0] d;
    @(negedge clk);
    irqIn[6] = 1'b1;
    @(negedge clk);
    busRead(3'd0, d);
    check("R4 read in edge cycle returns old byte", d, 8'h00);
    irqIn[6] = 1'b0;
    busRead(3'd0, d); check("R4 colliding edge survives", d, 8'h40);
    busRead(3'd0, d); check("R4 cleared afterwards", d, 8'h00);
    idle(4);
  endtask

  task automatic t_readPath();
    logic [7:0] d;
    busWrite(3'd1, 8'h5A);
    busRead(3'd1, d); check("R9 data one cycle after strobe", d, 8'h5A);
    busAddr = 3'd0;
    idle(3);
    check("R9 read data held when idle", busRdata, 8'h5A);
    busRead(3'd6, d); check("R9 offset 6 reads zero", d, 8'h00);
    busRead(3'd7, d); check("R9 offset 7 reads zero", d, 8'h00);
    clearAll();
  endtask

  task automatic t_noRefire();
    logic [7:0] d;
    irqIn[0] = 1'b1;
    idle(5);
    busRead(3'd0, d); check("R10 first rise latched", d, 8'h01);
    idle(6);
    busRead(3'd0, d); check("R10 held high does not relatch", d, 8'h00);
    irqIn[0] = 1'b0;
    idle(5);
    busRead(3'd0, d); check("R10 falling edge not latched", d, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_maskRw();
    t_edgeMasked();
    t_bankIsolation();
    t_output();
    t_redip();
    t_level();
    t_collision();
    t_readPath();
    t_noRefire();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule